// File: doc/BRIEF.md
# Transmit Descriptor Ring Walker

This block is the transmit half of a packet DMA engine. Software places 32-byte descriptors in a ring in memory and hands each one to the hardware by setting its ownership bit. A single-cycle poll request starts a scan at the current descriptor pointer. For each descriptor that the hardware owns, the engine reads the control word, the size word and the buffer address. It then fetches the buffer one 32-bit word at a time and sends the bytes, least significant first, on a valid/ready byte stream. After that it rewrites the control word with the ownership bit cleared. Finally it either steps the pointer by 32 bytes or, when the descriptor carries the wrap flag, reloads the pointer from the ring base. The scan stops at the first descriptor that software still owns.

A frame can span several descriptors. Only the segment that carries the last-segment flag closes the frame. That segment marks its final byte with `txLast` and pulses `doneSet`, which the register file uses to set both the transmit-done and the normal-summary status bits. Some segments cannot be sent. In those cases the engine closes the frame with a single marker beat that carries `txErr` and pulses `errSet`. Memory is reached through one request/acknowledge port that carries one 32-bit word per transfer.

Top module: `txring_walker`

## Requirements
- R1: After reset `busy`, `txValid` and `memReq` are low and `curDescPtr` is 0. A `ringLoad` pulse loads `curDescPtr` from `ringBase`.
- R2: A `pollDemand` pulse starts a scan at `curDescPtr`. If bit 31 (ownership) of the control word at offset 0 is 0, the scan ends with no data beat, no memory write and no pointer change. While idle the block drives neither `txValid` nor `memReq`.
- R3: The segment length is bits 11:0 plus bits 27:16 of the size word at offset 4. The bytes are read from the buffer address in the word at offset 8, with address bits 1:0 ignored. They are sent in ascending address order, with the low byte of each word first.
- R4: While `txValid` is high and `txReady` is low, `txData`, `txLast` and `txErr` hold their values.
- R5: When bit 29 of the control word (last segment) is set, the final byte of that segment carries `txLast`, and `doneSet` pulses in that handshake cycle. Segments without bit 29 produce neither `txLast` nor `doneSet`.
- R6: After a segment has been handled, the control word is written back to the address it was read from. Bit 31 is cleared and every other bit is unchanged.
- R7: After the write-back, `curDescPtr` becomes `ringBase` if control bit 21 (wrap) is set. Otherwise it becomes `curDescPtr` + 32. The scan then continues at the new pointer.
- R8: If the buffer-1 length (bits 11:0 of the size word) exceeds 2048, the buffer is not read. Instead one marker beat is sent with `txLast`=1, `txErr`=1 and data 0, and `errSet` pulses. The descriptor is still written back, and the pointer still moves.
- R9: If the bytes sent so far in the open frame plus the segment length would exceed 8192, that segment is replaced by the marker beat of R8. The next segment then starts a new frame.
- R10: A zero-length segment that has bit 29 set produces the marker beat of R8. A zero-length segment without bit 29 produces no beat, and the frame stays open.
- R11: A `pollDemand` that arrives while `busy` is high is remembered. When the current scan stops, one further scan starts at the same pointer.
- R12: Once `memReq` is raised, it stays high with the same `memAddr` and `memWe` until `memAck` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pollDemand | input | 1 | One-cycle request to scan the ring |
| ringLoad | input | 1 | Loads the current pointer from `ringBase` |
| ringBase | input | 32 | Byte address of the first descriptor of the ring |
| curDescPtr | output | 32 | Byte address of the current descriptor |
| memReq | output | 1 | Memory transfer request |
| memWe | output | 1 | 1 = write, 0 = read |
| memAddr | output | 32 | Byte address of the word being transferred |
| memWdata | output | 32 | Write data |
| memRdata | input | 32 | Read data, valid with `memAck` |
| memAck | input | 1 | Transfer complete |
| txValid | output | 1 | Byte beat is valid |
| txReady | input | 1 | Sink accepts the beat |
| txData | output | 8 | Frame byte |
| txLast | output | 1 | Final beat of a frame |
| txErr | output | 1 | Beat is an error marker that closes the frame |
| doneSet | output | 1 | Pulse: a frame finished normally |
| errSet | output | 1 | Pulse: a frame was closed by a marker |
| busy | output | 1 | A scan is in progress |

## Verification
The properties assume that `memAck` is only raised in answer to a pending `memReq`, and that it lasts one cycle. They also assume that `ringLoad` is pulsed only while `busy` is low and that `ringBase` is held steady during a scan. The bench memory model acknowledges each request one cycle after it is seen and then drops the acknowledge. The bench changes the ring base, reloads the pointer and rewrites descriptors only once `busy` has fallen. The single exception is the extra poll pulse used for R11.

// File: rtl/txring_pkg.sv
package txring_pkg;
  localparam int OWN_BIT  = 31;
  localparam int LAST_BIT = 29;
  localparam int WRAP_BIT = 21;

  typedef enum logic [3:0] {
    S_IDLE, S_RD_CTL, S_CHK, S_RD_SIZE, S_RD_BUF,
    S_EVAL, S_FETCH, S_SEND, S_MARK, S_WB
  } walkState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic       ldCtl;
    logic       ldSize;
    logic       ldBuf;
    logic       ldWord;
    logic       popByte;
    logic       stepPtr;
    logic       frameClr;
    logic [1:0] addrSel;   // 0 ctl word, 1 size word, 2 buffer ptr word, 3 buffer data
  } dpStrobe_t;

  // flags from datapath to control
  typedef struct packed {
    logic owned;
    logic lastSeg;
    logic segZero;
    logic segBad;
    logic finalByte;
    logic wordEmpty;
  } dpFlag_t;
endpackage

// File: rtl/txring_datapath.sv
module txring_datapath
  import txring_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DESC_BYTES = 32,
  parameter int MAX_SEG    = 2048,
  parameter int MAX_FRAME  = 8192
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         stb,
  input  logic              ringLoad,
  input  logic [ADDR_W-1:0] ringBase,
  input  logic [31:0]       memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [31:0]       memWdata,
  output logic [7:0]        byteOut,
  output logic [ADDR_W-1:0] curPtr,
  output dpFlag_t           flg
);
  localparam int SEG_W   = 13;                       // two 12-bit lengths summed
  localparam int FRAME_W = $clog2(MAX_FRAME + 1);
  localparam logic [ADDR_W-1:0] OFS_SIZE = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] OFS_BUF  = ADDR_W'(8);

  logic [31:0]        ctlWord, wordReg;
  logic [ADDR_W-1:0]  bufPtr;
  logic [SEG_W-1:0]   segLen, remain;
  logic               b1Big;
  logic [1:0]         byteIdx;
  logic [FRAME_W-1:0] frameLen;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curPtr   <= '0;
      ctlWord  <= '0;
      wordReg  <= '0;
      bufPtr   <= '0;
      segLen   <= '0;
      remain   <= '0;
      b1Big    <= 1'b0;
      byteIdx  <= '0;
      frameLen <= '0;
    end else begin
      if (ringLoad)
        curPtr <= ringBase;
      else if (stb.stepPtr)
        curPtr <= ctlWord[WRAP_BIT] ? ringBase : curPtr + ADDR_W'(DESC_BYTES);
      if (stb.ldCtl) ctlWord <= memRdata;
      if (stb.ldSize) begin
        segLen <= SEG_W'(memRdata[11:0]) + SEG_W'(memRdata[27:16]);
        b1Big  <= 32'(memRdata[11:0]) > 32'(MAX_SEG);
      end
      if (stb.ldBuf) begin
        bufPtr  <= {memRdata[ADDR_W-1:2], 2'b00};
        remain  <= segLen;
        byteIdx <= 2'd0;
      end
      if (stb.ldWord) begin
        wordReg <= memRdata;
        bufPtr  <= bufPtr + ADDR_W'(4);
      end
      if (stb.popByte) begin
        remain  <= remain - SEG_W'(1);
        byteIdx <= byteIdx + 2'd1;
      end
      if (stb.frameClr)
        frameLen <= '0;
      else if (stb.popByte)
        frameLen <= frameLen + FRAME_W'(1);
    end
  end

  always_comb begin
    case (stb.addrSel)
      2'd0:    memAddr = curPtr;
      2'd1:    memAddr = curPtr + OFS_SIZE;
      2'd2:    memAddr = curPtr + OFS_BUF;
      default: memAddr = bufPtr;
    endcase
  end

  assign memWdata      = {1'b0, ctlWord[30:0]};
  assign byteOut       = wordReg[8*byteIdx +: 8];
  assign flg.owned     = ctlWord[OWN_BIT];
  assign flg.lastSeg   = ctlWord[LAST_BIT];
  assign flg.segZero   = (segLen == '0);
  assign flg.segBad    = b1Big || ((32'(frameLen) + 32'(segLen)) > 32'(MAX_FRAME));
  assign flg.finalByte = (remain == SEG_W'(1));
  assign flg.wordEmpty = (byteIdx == 2'd3);
endmodule

// File: rtl/txring_ctrl.sv
module txring_ctrl
  import txring_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      pollDemand,
  input  logic      memAck,
  input  logic      txReady,
  input  dpFlag_t   flg,
  output dpStrobe_t stb,
  output logic      memReq,
  output logic      memWe,
  output logic      txValid,
  output logic      txLast,
  output logic      txErr,
  output logic      doneSet,
  output logic      errSet,
  output logic      busy
);
  walkState_t state, nextState;
  logic       pendPoll;
  logic       stopNow;

  assign stopNow = (state == S_CHK) && !flg.owned;
  assign busy    = (state != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_IDLE;
      pendPoll <= 1'b0;
    end else begin
      state <= nextState;
      if (stopNow)
        pendPoll <= 1'b0;
      else if (pollDemand && busy)
        pendPoll <= 1'b1;
    end
  end

  always_comb begin
    nextState = state;
    stb       = '0;
    memReq    = 1'b0;
    memWe     = 1'b0;
    txValid   = 1'b0;
    txLast    = 1'b0;
    txErr     = 1'b0;
    doneSet   = 1'b0;
    errSet    = 1'b0;
    case (state)
      S_IDLE: if (pollDemand) nextState = S_RD_CTL;
      S_RD_CTL: begin
        memReq = 1'b1;
        stb.addrSel = 2'd0;
        if (memAck) begin
          stb.ldCtl = 1'b1;
          nextState = S_CHK;
        end
      end
      S_CHK: begin
        if (!flg.owned) nextState = (pendPoll || pollDemand) ? S_RD_CTL : S_IDLE;
        else            nextState = S_RD_SIZE;
      end
      S_RD_SIZE: begin
        memReq = 1'b1;
        stb.addrSel = 2'd1;
        if (memAck) begin
          stb.ldSize = 1'b1;
          nextState = S_RD_BUF;
        end
      end
      S_RD_BUF: begin
        memReq = 1'b1;
        stb.addrSel = 2'd2;
        if (memAck) begin
          stb.ldBuf = 1'b1;
          nextState = S_EVAL;
        end
      end
      S_EVAL: begin
        if (flg.segBad || (flg.segZero && flg.lastSeg)) nextState = S_MARK;
        else if (flg.segZero)                          nextState = S_WB;
        else                                           nextState = S_FETCH;
      end
      S_FETCH: begin
        memReq = 1'b1;
        stb.addrSel = 2'd3;
        if (memAck) begin
          stb.ldWord = 1'b1;
          nextState = S_SEND;
        end
      end
      S_SEND: begin
        txValid = 1'b1;
        txLast  = flg.lastSeg && flg.finalByte;
        if (txReady) begin
          stb.popByte = 1'b1;
          if (flg.finalByte) begin
            if (flg.lastSeg) begin
              doneSet = 1'b1;
              stb.frameClr = 1'b1;
            end
            nextState = S_WB;
          end else if (flg.wordEmpty) begin
            nextState = S_FETCH;
          end
        end
      end
      S_MARK: begin
        txValid = 1'b1;
        txLast  = 1'b1;
        txErr   = 1'b1;
        if (txReady) begin
          errSet = 1'b1;
          stb.frameClr = 1'b1;
          nextState = S_WB;
        end
      end
      S_WB: begin
        memReq = 1'b1;
        memWe  = 1'b1;
        stb.addrSel = 2'd0;
        if (memAck) begin
          stb.stepPtr = 1'b1;
          nextState = S_RD_CTL;
        end
      end
      default: nextState = S_IDLE;
    endcase
  end
endmodule

// File: rtl/txring_walker.sv
module txring_walker
  import txring_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DESC_BYTES = 32,
  parameter int MAX_SEG    = 2048,
  parameter int MAX_FRAME  = 8192
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pollDemand,
  input  logic              ringLoad,
  input  logic [ADDR_W-1:0] ringBase,
  output logic [ADDR_W-1:0] curDescPtr,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [31:0]       memWdata,
  input  logic [31:0]       memRdata,
  input  logic              memAck,
  output logic              txValid,
  input  logic              txReady,
  output logic [7:0]        txData,
  output logic              txLast,
  output logic              txErr,
  output logic              doneSet,
  output logic              errSet,
  output logic              busy
);
  dpStrobe_t  stb;
  dpFlag_t    flg;
  logic [7:0] byteOut;

  txring_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .pollDemand(pollDemand), .memAck(memAck),
    .txReady(txReady), .flg(flg), .stb(stb), .memReq(memReq), .memWe(memWe),
    .txValid(txValid), .txLast(txLast), .txErr(txErr), .doneSet(doneSet),
    .errSet(errSet), .busy(busy)
  );

  txring_datapath #(
    .ADDR_W(ADDR_W), .DESC_BYTES(DESC_BYTES), .MAX_SEG(MAX_SEG), .MAX_FRAME(MAX_FRAME)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .ringLoad(ringLoad), .ringBase(ringBase),
    .memRdata(memRdata), .memAddr(memAddr), .memWdata(memWdata),
    .byteOut(byteOut), .curPtr(curDescPtr), .flg(flg)
  );

  assign txData = txErr ? 8'h00 : byteOut;
endmodule

// File: rtl/txring_walker_chk.sv
module txring_walker_chk #(
  parameter int ADDR_W = 32,
  parameter int DESC_BYTES = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              ringLoad,
  input logic [ADDR_W-1:0] ringBase,
  input logic [ADDR_W-1:0] curDescPtr,
  input logic              memReq,
  input logic              memWe,
  input logic [ADDR_W-1:0] memAddr,
  input logic [31:0]       memWdata,
  input logic              memAck,
  input logic              txValid,
  input logic              txReady,
  input logic [7:0]        txData,
  input logic              txLast,
  input logic              txErr,
  input logic              doneSet,
  input logic              errSet,
  input logic              busy
);
  p_hold_beat_r4: assert property (@(posedge clk) disable iff (!rstN)
    txValid && !txReady |=> txValid && $stable(txData) && $stable(txLast) && $stable(txErr));

  p_req_hold_r12: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> memReq && $stable(memAddr) && $stable(memWe));

  p_wb_clears_own_r6: assert property (@(posedge clk) disable iff (!rstN)
    memReq && memWe |-> !memWdata[31]);

  p_done_beat_r5: assert property (@(posedge clk) disable iff (!rstN)
    doneSet |-> txValid && txReady && txLast && !txErr);

  p_marker_r8: assert property (@(posedge clk) disable iff (!rstN)
    errSet |-> txValid && txReady && txLast && txErr && (txData == 8'h00));

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !txValid && !memReq);

  p_ptr_step_r7: assert property (@(posedge clk) disable iff (!rstN)
    memReq && memWe && memAck && !ringLoad |=>
      (curDescPtr == $past(ringBase)) || (curDescPtr == $past(curDescPtr) + ADDR_W'(DESC_BYTES)));
endmodule

bind txring_walker txring_walker_chk #(.ADDR_W(ADDR_W), .DESC_BYTES(DESC_BYTES)) u_chk (
  .clk(clk), .rstN(rstN), .ringLoad(ringLoad), .ringBase(ringBase),
  .curDescPtr(curDescPtr), .memReq(memReq), .memWe(memWe), .memAddr(memAddr),
  .memWdata(memWdata), .memAck(memAck), .txValid(txValid), .txReady(txReady),
  .txData(txData), .txLast(txLast), .txErr(txErr), .doneSet(doneSet),
  .errSet(errSet), .busy(busy)
);

// File: tb/txring_walker_bench.sv
`timescale 1ns/1ps
module txring_walker_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        pollDemand = 1'b0;
  logic        ringLoad = 1'b0;
  logic [31:0] ringBase = 32'h0;
  logic [31:0] curDescPtr, memAddr, memWdata;
  logic [31:0] memRdata = 32'h0;
  logic        memReq, memWe, txValid, txLast, txErr, doneSet, errSet, busy;
  logic        memAck = 1'b0;
  logic        txReady = 1'b1;
  logic [7:0]  txData;

  always #5 clk = ~clk;

  txring_walker u_txring_walker (
    .clk(clk), .rstN(rstN), .pollDemand(pollDemand), .ringLoad(ringLoad),
    .ringBase(ringBase), .curDescPtr(curDescPtr), .memReq(memReq), .memWe(memWe),
    .memAddr(memAddr), .memWdata(memWdata), .memRdata(memRdata), .memAck(memAck),
    .txValid(txValid), .txReady(txReady), .txData(txData), .txLast(txLast),
    .txErr(txErr), .doneSet(doneSet), .errSet(errSet), .busy(busy)
  );

  // memory model: 16 KB, one-cycle acknowledge
  logic [31:0] mem [0:4095];
  logic [31:0] watchAddr = 32'hFFFF_FFFF;
  int          watchCnt = 0;
  int          writeCnt = 0;

  always @(posedge clk) begin
    memAck <= 1'b0;
    if (memReq && !memAck) begin
      memAck <= 1'b1;
      if (memWe) begin
        mem[memAddr[13:2]] <= memWdata;
        writeCnt <= writeCnt + 1;
      end else begin
        memRdata <= mem[memAddr[13:2]];
        if (memAddr == watchAddr) watchCnt <= watchCnt + 1;
      end
    end
  end

  // ready pattern
  int readyMode = 0;
  int cyc = 0;
  initial forever begin
    @(posedge clk);
    #1;
    cyc++;
    txReady = (readyMode == 0) ? 1'b1 : ((cyc % 3) != 0);
  end

  // stream monitor
  logic [7:0] cap [0:16383];
  int capN = 0, beats = 0, errBeats = 0, lastCnt = 0, doneCnt = 0, errCnt = 0;
  always @(negedge clk) begin
    if (rstN) begin
      if (txValid && txReady) begin
        beats++;
        if (txErr) errBeats++;
        else begin cap[capN] = txData; capN++; end
        if (txLast) lastCnt++;
      end
      if (doneSet) doneCnt++;
      if (errSet) errCnt++;
    end
  end

  int checks = 0, fails = 0;
  bit finished = 0;

  task automatic chk(input string req, input logic ok, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int a);
    return 8'(a) ^ 8'(a >> 8) ^ 8'h3C;
  endfunction

  task automatic clearCap();
    capN = 0; beats = 0; errBeats = 0; lastCnt = 0; doneCnt = 0; errCnt = 0;
  endtask

  task automatic putDesc(input logic [31:0] a, input logic [31:0] ctl,
                         input logic [15:0] s1, input logic [15:0] s2, input logic [31:0] buf_a);
    mem[a[13:2]]     = ctl;
    mem[a[13:2] + 1] = {s2, s1};
    mem[a[13:2] + 2] = buf_a;
    mem[a[13:2] + 3] = 32'h0;
  endtask

  task automatic poll();
    @(negedge clk); pollDemand = 1'b1;
    @(negedge clk); pollDemand = 1'b0;
    while (busy) @(negedge clk);
  endtask

  task automatic reload(input logic [31:0] b);
    @(negedge clk); ringBase = b; ringLoad = 1'b1;
    @(negedge clk); ringLoad = 1'b0;
  endtask

  task automatic chkBytes(input string req, input logic [31:0] bufA, input int n, input int startIdx);
    int bad = 0;
    for (int i = 0; i < n; i++)
      if (cap[startIdx + i] != pat(int'(bufA) + i)) bad++;
    chk(req, bad == 0, 64'(bad), 64'd0);
  endtask

  typedef struct packed {
    logic [15:0] s1;
    logic [15:0] s2;
    logic        wrap;
    logic [1:0]  boff;
    logic [15:0] expBytes;
    logic        expErr;
  } vec_t;

  localparam vec_t VECS [0:7] = '{
    '{16'd5,    16'd0,    1'b0, 2'd0, 16'd5,    1'b0},  // R3 single buffer
    '{16'd3,    16'd4,    1'b0, 2'd0, 16'd7,    1'b0},  // R3 two lengths added
    '{16'd2048, 16'd0,    1'b0, 2'd0, 16'd2048, 1'b0},  // R8 boundary accepted
    '{16'd2049, 16'd0,    1'b0, 2'd0, 16'd0,    1'b1},  // R8 oversize buffer 1
    '{16'd0,    16'd0,    1'b0, 2'd0, 16'd0,    1'b1},  // R10 empty last segment
    '{16'hF008, 16'hA000, 1'b0, 2'd0, 16'd8,    1'b0},  // R3 upper size bits ignored
    '{16'd6,    16'd0,    1'b1, 2'd0, 16'd6,    1'b0},  // R7 wrap to base
    '{16'd9,    16'd0,    1'b0, 2'd3, 16'd9,    1'b0}   // R3 low address bits ignored
  };

  localparam logic [31:0] BASE = 32'h0000_0040;
  localparam logic [31:0] BUFA = 32'h0000_1000;

  initial begin
    for (int w = 0; w < 4096; w++)
      mem[w] = (w < 256) ? 32'h0 :
               {pat(w*4+3), pat(w*4+2), pat(w*4+1), pat(w*4)};
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 reset busy/valid/req", !busy && !txValid && !memReq, {busy, txValid, memReq}, 0);
    chk("R1 reset pointer", curDescPtr == 0, curDescPtr, 0);
    reload(BASE);
    chk("R1 pointer load", curDescPtr == BASE, curDescPtr, BASE);

    // R2 software-owned descriptor stops the scan
    mem[BASE[13:2]] = 32'h0000_1234;
    clearCap(); writeCnt = 0;
    poll();
    chk("R2 no beat on unowned", beats == 0, beats, 0);
    chk("R2 no write on unowned", writeCnt == 0 && mem[BASE[13:2]] == 32'h0000_1234, writeCnt, 0);
    chk("R2 pointer unchanged", curDescPtr == BASE, curDescPtr, BASE);

    // vector table
    for (int k = 0; k < 8; k++) begin
      logic [31:0] ptr, nxt, ctl;
      vec_t v;
      v = VECS[k];
      readyMode = k % 2;
      ptr = curDescPtr;
      nxt = v.wrap ? BASE : ptr + 32;
      ctl = 32'h8000_0ABC | (32'd1 << 29) | (32'(v.wrap) << 21);
      if (nxt != ptr) mem[nxt[13:2]] = 32'h0;
      putDesc(ptr, ctl, v.s1, v.s2, BUFA | 32'(v.boff));
      clearCap();
      poll();
      chk($sformatf("R3 vec%0d byte count", k), capN == int'(v.expBytes), capN, v.expBytes);
      chkBytes($sformatf("R3 vec%0d byte values", k), BUFA, int'(v.expBytes), 0);
      chk($sformatf("R8 vec%0d errSet count", k), errCnt == int'(v.expErr), errCnt, v.expErr);
      chk($sformatf("R5 vec%0d doneSet count", k), doneCnt == int'(!v.expErr), doneCnt, !v.expErr);
      chk($sformatf("R5 vec%0d txLast count", k), lastCnt == 1, lastCnt, 1);
      chk($sformatf("R6 vec%0d write-back", k), mem[ptr[13:2]] == (ctl & 32'h7FFF_FFFF),
          mem[ptr[13:2]], ctl & 32'h7FFF_FFFF);
      chk($sformatf("R7 vec%0d next pointer", k), curDescPtr == nxt, curDescPtr, nxt);
    end
    readyMode = 0;

    // R5 multi-segment frame, last marker only on third
    reload(BASE);
    putDesc(BASE,       32'h8000_0000, 16'd3, 16'd0, BUFA);
    putDesc(BASE + 32,  32'h8000_0000, 16'd4, 16'd0, BUFA + 32'h200);
    putDesc(BASE + 64,  32'hA000_0000, 16'd5, 16'd0, BUFA + 32'h400);
    mem[(BASE + 96) >> 2] = 32'h0;
    clearCap();
    poll();
    chk("R5 multi-seg bytes", capN == 12, capN, 12);
    chkBytes("R3 multi-seg seg1", BUFA, 3, 0);
    chkBytes("R3 multi-seg seg2", BUFA + 32'h200, 4, 3);
    chkBytes("R3 multi-seg seg3", BUFA + 32'h400, 5, 7);
    chk("R5 multi-seg single done", doneCnt == 1 && lastCnt == 1, {doneCnt[31:0], lastCnt[31:0]}, {32'd1, 32'd1});
    chk("R7 multi-seg pointer", curDescPtr == BASE + 96, curDescPtr, BASE + 96);

    // R9 frame longer than limit
    reload(BASE);
    for (int s = 0; s < 5; s++)
      putDesc(BASE + 32*s, (s == 4) ? 32'hA000_0000 : 32'h8000_0000, 16'd2000, 16'd0, BUFA);
    mem[(BASE + 160) >> 2] = 32'h0;
    clearCap();
    poll();
    chk("R9 bytes before marker", capN == 8000, capN, 8000);
    chk("R9 marker raised", errCnt == 1 && errBeats == 1 && doneCnt == 0, {errCnt[31:0], doneCnt[31:0]}, {32'd1, 32'd0});
    chk("R9 pointer after frame", curDescPtr == BASE + 160, curDescPtr, BASE + 160);

    // R10 zero-length middle segment keeps frame open
    reload(BASE);
    putDesc(BASE,      32'h8000_0000, 16'd0, 16'd0, BUFA);
    putDesc(BASE + 32, 32'hA000_0000, 16'd6, 16'd0, BUFA);
    mem[(BASE + 64) >> 2] = 32'h0;
    clearCap();
    poll();
    chk("R10 empty middle segment", beats == 6 && doneCnt == 1 && errCnt == 0, beats, 6);
    chk("R10 empty middle write-back", mem[BASE[13:2]] == 32'h0, mem[BASE[13:2]], 0);

    // R11 pending poll gives one extra scan
    reload(BASE);
    putDesc(BASE, 32'hA000_0000, 16'd40, 16'd0, BUFA);
    mem[(BASE + 32) >> 2] = 32'h0;
    watchAddr = BASE + 32; watchCnt = 0;
    clearCap();
    @(negedge clk); pollDemand = 1'b1;
    @(negedge clk); pollDemand = 1'b0;
    repeat (10) @(negedge clk);
    chk("R11 still busy at second poll", busy, busy, 1);
    pollDemand = 1'b1;
    @(negedge clk); pollDemand = 1'b0;
    while (busy) @(negedge clk);
    chk("R11 extra scan", watchCnt == 2, watchCnt, 2);
    chk("R11 frame bytes", capN == 40, capN, 40);
    watchAddr = curDescPtr; watchCnt = 0;
    poll();
    chk("R11 no extra scan without pending", watchCnt == 1, watchCnt, 1);

    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule